// File: doc/BRIEF.md
# Batched SDRAM Refresh Scheduler

This block takes the SDRAM command pins away from normal traffic at a fixed interval and spends that time on refresh. A free-running counter measures an interval that covers four nominal refresh periods. When it expires, the block stalls the request front end at once, whatever that front end is doing. It then waits until any write already in progress has finished. After that it closes every bank with a precharge-all. This precharge is sent even if no bank is open. It then sends a batch of REFRESH commands, each separated by the refresh-cycle time, and gives the command bus back.

The block has one input from the datapath, a write-busy flag. It drives a stall to the front end, a flag showing that it owns the command bus, the four command strobes and the address bus. It also drives a one-cycle pulse that tells the bank manager every bank is now closed, so that the manager can drop its open-row records. Power-up initialisation of the memory is handled elsewhere.

The controller is a seven-state machine:

- IDLE: normal traffic. It leaves for DRAIN when the interval expires.
- DRAIN: the block waits for write-busy to go low, then moves to PRECHARGE.
- PRECHARGE: lasts one cycle. The precharge-all is sent and the closed pulse is raised. The next state is WAIT_RP.
- WAIT_RP: the block waits out the precharge time, then moves to REFRESH.
- REFRESH: lasts one cycle. A refresh is sent and the next state is WAIT_RFC.
- WAIT_RFC: the block waits out the refresh-cycle time. It goes back to REFRESH while refreshes remain in the batch. After the last one it goes to DONE.
- DONE: lasts one cycle. The bus is released and the machine returns to IDLE.

A 2-bit index counts the refreshes in the batch.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, stall, bus_own and banks_closed are low. The command pins carry NOP, {cs_n,ras_n,cas_n,we_n} = 0111, and cmd_addr is all zeros.
- R2: The interval expires for the first time after PERIOD_CYC-1 clock edges following reset release. It then expires every PERIOD_CYC edges. stall is high in the expiry cycle whatever wr_busy is doing.
- R3: From expiry until the precharge is sent, stall stays high, bus_own stays low and NOP is driven. The precharge is sent in the cycle after the first cycle in which wr_busy is seen low.
- R4: Every burst begins with exactly one precharge-all, encoded as 0010 with cmd_addr bit AP_BIT high and every other address bit low. banks_closed is high in that cycle only.
- R5: The first REFRESH, encoded as 0001 with cmd_addr zero, is sent exactly TRP_CYC cycles after the precharge-all.
- R6: Each burst sends exactly NREF REFRESH commands (4 by default), with TRP_CYC+k*TRFC_CYC cycles between the precharge and refresh number k.
- R7: Every cycle between commands in a burst carries NOP. bus_own is high from the precharge-all through the end of the last refresh-cycle wait, and stall is high whenever bus_own is high.
- R8: stall and bus_own fall together exactly TRFC_CYC cycles after the last REFRESH. The block then returns to IDLE and drives NOP.
- R9: The time spent draining and refreshing does not shift later expiries. They stay at the fixed positions given in R2.
- R10: Outside the drain phase, wr_busy has no effect on stall, bus_own, banks_closed or the command pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_busy | input | 1 | High while a write burst is still in progress |
| stall | output | 1 | Holds off new requests at the front end |
| bus_own | output | 1 | High while this block drives the command bus |
| cmd_cs_n | output | 1 | Chip-select strobe, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write strobe, active low |
| cmd_addr | output | ADDR_W | Command address; bit AP_BIT selects all banks on precharge |
| banks_closed | output | 1 | One-cycle pulse when every bank has been closed |

## Verification
The checker tests local invariants on every cycle:

- the closed pulse always coincides with a precharge-all and never lasts two cycles;
- no command is driven unless the bus is owned, and ownership implies stall;
- the machine stays in drain while a write is still busy;
- every fall of stall comes after exactly NREF refreshes.

Some properties span hundreds of cycles and can only be shown by the bench scenarios, which compare every output against a timeline derived from the requirements:

- the expiry positions and the absence of drift;
- the exact spacing of the precharge time and the refresh-cycle time;
- the one-cycle delay after a long write drain;
- the fact that wr_busy has no effect outside the drain phase.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RFC,
        ST_DONE
    } rs_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;

endpackage

// File: rtl/rs_period_timer.sv
module rs_period_timer #(
    parameter int PERIOD_CYC = 6240
) (
    input  logic clk,
    input  logic rst_n,
    output logic expire
);
    localparam int PW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [PW-1:0] RELOAD = PW'(PERIOD_CYC - 1);

    logic [PW-1:0] cnt;

    // Free-running: never paused by the burst, so expiries stay on a fixed grid.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= RELOAD;
        else if (cnt == '0)  cnt <= RELOAD;
        else                 cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == '0);
endmodule

// File: rtl/rs_gap_timer.sv
module rs_gap_timer #(
    parameter int TRP_CYC  = 4,
    parameter int TRFC_CYC = 52
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_rp,
    input  logic load_rfc,
    input  logic run,
    output logic done
);
    localparam int GAP_MAX = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
    localparam int GW      = (GAP_MAX > 2) ? $clog2(GAP_MAX) : 1;
    // A wait state lasts N-1 cycles, so command-to-command spacing is N.
    localparam logic [GW-1:0] RP_LOAD  = GW'(TRP_CYC - 2);
    localparam logic [GW-1:0] RFC_LOAD = GW'(TRFC_CYC - 2);

    logic [GW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (load_rp)            cnt <= RP_LOAD;
        else if (load_rfc)           cnt <= RFC_LOAD;
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/rs_cmd_drive.sv
module rs_cmd_drive
    import refsched_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int AP_BIT = 10
) (
    input  rs_state_t         state,
    input  logic              expire,
    output logic              stall,
    output logic              bus_own,
    output logic [3:0]        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              banks_closed
);
    localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

    always_comb begin
        stall        = 1'b1;
        bus_own      = 1'b1;
        cmd          = CMD_NOP;
        addr         = '0;
        banks_closed = 1'b0;
        unique case (state)
            ST_IDLE: begin
                stall   = expire;
                bus_own = 1'b0;
            end
            ST_DRAIN: begin
                bus_own = 1'b0;
            end
            ST_PRECHARGE: begin
                cmd          = CMD_PRE;
                addr         = AP_MASK;
                banks_closed = 1'b1;
            end
            ST_WAIT_RP: begin
            end
            ST_REFRESH: begin
                cmd = CMD_REF;
            end
            ST_WAIT_RFC: begin
            end
            ST_DONE: begin
                stall   = 1'b0;
                bus_own = 1'b0;
            end
            default: begin
                stall   = 1'b0;
                bus_own = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsched_pkg::*;
#(
    parameter int PERIOD_CYC = 6240,
    parameter int TRP_CYC    = 4,
    parameter int TRFC_CYC   = 52,
    parameter int NREF       = 4,
    parameter int ADDR_W     = 16,
    parameter int AP_BIT     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_busy,
    output logic              stall,
    output logic              bus_own,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              banks_closed
);
    localparam int RW = (NREF > 2) ? $clog2(NREF) : 1;
    localparam logic [RW-1:0] LAST_IDX = RW'(NREF - 1);

    rs_state_t     state, state_nx;
    logic [RW-1:0] ref_idx;
    logic          expire;
    logic          gap_done;
    logic [3:0]    cmd;

    rs_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire)
    );

    rs_gap_timer #(.TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_rp  (state == ST_PRECHARGE),
        .load_rfc (state == ST_REFRESH),
        .run      (state == ST_WAIT_RP || state == ST_WAIT_RFC),
        .done     (gap_done)
    );

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (expire)   state_nx = ST_DRAIN;
            ST_DRAIN:     if (!wr_busy) state_nx = ST_PRECHARGE;
            ST_PRECHARGE:               state_nx = ST_WAIT_RP;
            ST_WAIT_RP:   if (gap_done) state_nx = ST_REFRESH;
            ST_REFRESH:                 state_nx = ST_WAIT_RFC;
            ST_WAIT_RFC:  if (gap_done) state_nx = (ref_idx == LAST_IDX) ? ST_DONE : ST_REFRESH;
            ST_DONE:                    state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    // State register and batch index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ref_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_PRECHARGE)
                ref_idx <= '0;
            else if (state == ST_WAIT_RFC && gap_done && ref_idx != LAST_IDX)
                ref_idx <= ref_idx + 1'b1;
        end
    end

    rs_cmd_drive #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_drive (
        .state        (state),
        .expire       (expire),
        .stall        (stall),
        .bus_own      (bus_own),
        .cmd          (cmd),
        .addr         (cmd_addr),
        .banks_closed (banks_closed)
    );

    assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int NREF   = 4,
    parameter int ADDR_W = 16,
    parameter int AP_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_busy,
    input logic              stall,
    input logic              bus_own,
    input logic              cmd_cs_n,
    input logic              cmd_ras_n,
    input logic              cmd_cas_n,
    input logic              cmd_we_n,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              banks_closed
);
    localparam int CW = $clog2(NREF + 2) + 1;

    logic [3:0]    pins;
    logic          is_nop, is_pre, is_ref;
    logic [CW-1:0] refs_seen;

    assign pins   = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
    assign is_nop = (pins == 4'b0111);
    assign is_pre = (pins == 4'b0010);
    assign is_ref = (pins == 4'b0001);

    always_ff @(posedge clk) begin
        if (!rst_n)            refs_seen <= '0;
        else if (banks_closed) refs_seen <= '0;
        else if (is_ref)       refs_seen <= refs_seen + 1'b1;
    end

    // R4
    pre_with_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        banks_closed |-> (is_pre && cmd_addr[AP_BIT]));

    // R4
    closed_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        banks_closed |=> !banks_closed);

    // R7
    cmd_needs_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |-> bus_own);

    // R7
    own_implies_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |-> stall);

    // R3
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !bus_own && wr_busy) |=> (!bus_own && stall));

    // R6
    batch_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> (refs_seen == CW'(NREF)));

    // R8
    release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> (!bus_own && is_nop));
endmodule

bind refresh_sched refresh_sched_chk #(
    .NREF(NREF), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_busy      (wr_busy),
    .stall        (stall),
    .bus_own      (bus_own),
    .cmd_cs_n     (cmd_cs_n),
    .cmd_ras_n    (cmd_ras_n),
    .cmd_cas_n    (cmd_cas_n),
    .cmd_we_n     (cmd_we_n),
    .cmd_addr     (cmd_addr),
    .banks_closed (banks_closed)
);

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
    localparam int PERIOD = 200;
    localparam int TRP    = 3;
    localparam int TRFC   = 8;
    localparam int NREF   = 4;
    localparam int AW     = 16;
    localparam int APB    = 10;
    localparam int RUN_CYC  = 16 * PERIOD;
    localparam int BURST_END = TRP + NREF * TRFC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_busy = 1'b0;
    logic stall, bus_own, cs_n, ras_n, cas_n, we_n, closed;
    logic [AW-1:0] addr;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    refresh_sched #(
        .PERIOD_CYC(PERIOD), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
        .NREF(NREF), .ADDR_W(AW), .AP_BIT(APB)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_busy(wr_busy),
        .stall(stall), .bus_own(bus_own),
        .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
        .cmd_addr(addr), .banks_closed(closed)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp_v, $time);
        end
    endtask

    // Expected command in a burst, from offset t after the precharge-all (R4/R5/R6/R7)
    function automatic logic [3:0] exp_burst_cmd(input int t);
        if (t == 0) return 4'b0010;
        for (int k = 0; k < NREF; k++)
            if (t == TRP + k * TRFC) return 4'b0001;
        return 4'b0111;
    endfunction

    function automatic bit is_expiry(input int n);
        return (n % PERIOD) == (PERIOD - 1);
    endfunction

    task automatic check_outputs(input logic es, input logic eo, input logic [3:0] ec,
                                 input logic [AW-1:0] ea, input logic ecl, input string req);
        chk(stall == es,   {req, " stall"},   int'(stall), int'(es));
        chk(bus_own == eo, {req, " bus_own"}, int'(bus_own), int'(eo));
        chk({cs_n, ras_n, cas_n, we_n} == ec, {req, " cmd"}, int'({cs_n, ras_n, cas_n, we_n}), int'(ec));
        chk(addr == ea,    {req, " addr"},    int'(addr), int'(ea));
        chk(closed == ecl, {req, " closed"},  int'(closed), int'(ecl));
    endtask

    initial begin
        int phase;   // 0 idle, 1 drain, 2 burst
        int t;
        int busy_left;
        int n;
        logic [3:0] ec;
        void'($urandom(32'd20240611));
        phase = 0; t = 0; busy_left = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: under reset
        check_outputs(1'b0, 1'b0, 4'b0111, '0, 1'b0, "R1");
        rst_n = 1'b1;
        // R1: first cycle after release (no edge yet)
        check_outputs(1'b0, 1'b0, 4'b0111, '0, 1'b0, "R1");

        for (n = 1; n <= RUN_CYC; n++) begin
            @(negedge clk);
            case (phase)
                0: begin
                    // R2 R9 R10: stall only at fixed expiry positions, regardless of wr_busy
                    check_outputs(is_expiry(n), 1'b0, 4'b0111, '0, 1'b0,
                                  is_expiry(n) ? "R2" : "R10");
                end
                1: check_outputs(1'b1, 1'b0, 4'b0111, '0, 1'b0, "R3");
                default: begin
                    if (t == BURST_END) begin
                        check_outputs(1'b0, 1'b0, 4'b0111, '0, 1'b0, "R8");
                    end else begin
                        ec = exp_burst_cmd(t);
                        check_outputs(1'b1, 1'b1, ec,
                                      (ec == 4'b0010) ? (AW'(1) << APB) : '0,
                                      (t == 0),
                                      (t == 0) ? "R4" : (ec == 4'b0001 ? "R6" : "R7"));
                        if (t == TRP) chk(ec == 4'b0001, "R5 first refresh", int'(ec), 1);
                    end
                end
            endcase

            // choose next wr_busy
            if ((n / PERIOD) == 2 && (n % PERIOD) == PERIOD - 6) busy_left = 30;  // long drain
            if ((n / PERIOD) == 4 && (n % PERIOD) == PERIOD - 3) busy_left = 0;   // idle-at-expiry case
            if (busy_left == 0 && ($urandom % 4) == 0) busy_left = 1 + int'($urandom % 12);
            wr_busy = (busy_left > 0);
            if (busy_left > 0) busy_left--;

            // advance expected model
            case (phase)
                0: if (is_expiry(n)) phase = 1;
                1: if (!wr_busy) begin phase = 2; t = 0; end
                default: begin
                    if (t == BURST_END) phase = 0;
                    else t++;
                end
            endcase
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule